// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Controller

This block is a serial peripheral interface port that moves one byte at a time through a single shift register. Software reaches it over a small internal register bus with three registers: control, status and data. Writing the data register loads the outgoing byte. Reading it returns whatever the shift register holds, which is the received byte once a transfer has finished. A status flag reports that a byte has completed.

In master mode the block makes the serial clock itself, from a programmable divider of the system clock. It drives its serial data output and captures the slave's data line. In slave mode it follows an external serial clock and an active-low select. All three slave inputs pass through two-stage synchronisers, and clock edges are found on the synchronised copy. The system clock must therefore run at least four times faster than the external serial clock.

Clock idle level and clock phase can be chosen. A lone slave that uses the second-edge phase can be told to ignore its select pin. Data is always sent and received most significant bit first.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset the control register, the status register and the shift register read 0. The block is in slave mode and `sck_out`, `mosi_out` and `miso_out` are low.
- R2: The register map is decoded on `bus_addr`. Address 0 is control (read/write). Address 1 is status: bit 7 is the completion flag and the other bits read 0. Address 2 is data: a write loads the shift register and a read returns it. Address 3 reads 0.
- R3: The control fields are placed as follows. Bit 4 selects master mode (1) or slave mode (0). Bit 3 sets the clock idle level. Bit 2 sets the clock phase. Bit 5 is the ignore-select bit. The rate code is {bit 7, bit 1, bit 0}.
- R4: In master mode each half period of `sck_out` lasts D system cycles. For a rate code n from 0 to 6, D = 2^(n+1). For rate code 7, D = 1. A transfer has exactly 16 clock edges.
- R5: In master mode a data write while idle starts a transfer that sends the written byte MSB first on `mosi_out` and captures `miso_in`. With phase 0 the first bit is valid before the first edge, input is sampled on leading edges and output changes on trailing edges. With phase 1 output changes on leading edges and input is sampled on trailing edges. After the transfer a data read returns the received byte.
- R6: While master mode is idle, `sck_out` sits at the idle level. It returns to that level after the eighth bit.
- R7: The completion flag (status bit 7) is set when a whole byte has been shifted, in either mode.
- R8: The flag clears on a data register access (read or write) that follows a status read which saw the flag set. A data access with no such status read leaves the flag set.
- R9: A data register write during an active transfer is ignored: the byte being sent and the byte received are unaffected.
- R10: In slave mode with `ss_n_in` low, the block samples `mosi_in` and drives the loaded byte MSB first on `miso_out`, following `sck_in` with the selected idle level and phase. After 8 bits the data register holds the received byte.
- R11: With ignore-select set and phase 1, a slave transfer completes with `ss_n_in` held high.
- R12: With ignore-select set and phase 0, ignore-select has no effect. With `ss_n_in` high, clock edges are not counted, the flag stays 0 and the data register keeps the loaded byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while `bus_sel` is high |
| sck_out | output | 1 | Serial clock driven in master mode |
| mosi_out | output | 1 | Serial data out in master mode |
| miso_in | input | 1 | Serial data in, master mode |
| sck_in | input | 1 | External serial clock, slave mode |
| mosi_in | input | 1 | Serial data in, slave mode |
| ss_n_in | input | 1 | Active-low slave select |
| miso_out | output | 1 | Serial data out in slave mode |

## Verification
A wrong edge counter or phase decode shows up as a byte that is rotated or bit-shifted at the far end. It also shows as a flag that rises a half period early or late. Both are visible within one transfer of 16·D cycles. A wrong divider shows on the very next pair of `sck_out` transitions, because their spacing is no longer D. A wrong flag-clear or ignore-select decision shows on the next status read. So every fault is exposed within a single byte plus one register access.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int DIV_MAX = 128;
  localparam int DIV_W   = $clog2(DIV_MAX) + 1;

  localparam int BIT_CPHA   = 2;
  localparam int BIT_CPOL   = 3;
  localparam int BIT_MASTER = 4;
  localparam int BIT_IGNSS  = 5;
  localparam int BIT_RATEHI = 7;

  typedef struct packed {
    logic [2:0] rate;
    logic       ign_ss;
    logic       master;
    logic       cpol;
    logic       cpha;
  } spi_cfg_t;

  function automatic spi_cfg_t cfg_decode(input logic [7:0] c);
    spi_cfg_t r;
    r.rate   = {c[BIT_RATEHI], c[1:0]};
    r.ign_ss = c[BIT_IGNSS];
    r.master = c[BIT_MASTER];
    r.cpol   = c[BIT_CPOL];
    r.cpha   = c[BIT_CPHA];
    return r;
  endfunction

  // system cycles per half period of the serial clock
  function automatic logic [DIV_W-1:0] half_div(input logic [2:0] code);
    logic [DIV_W-1:0] one;
    one = '0;
    one[0] = 1'b1;
    if (code == 3'd7) return one;
    return one << (int'(code) + 1);
  endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             cpol,
  input  logic [DIV_W-1:0] hdiv,
  output logic             busy,
  output logic             sck,
  output logic             tick
);
  logic [DIV_W-1:0] hc;

  assign tick = busy && (hc >= hdiv - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hc   <= '0;
      sck  <= 1'b0;
    end else if (!busy) begin
      hc   <= '0;
      sck  <= cpol;
      busy <= start;
    end else begin
      if (tick) begin
        hc  <= '0;
        sck <= ~sck;
      end else begin
        hc <= hc + 1'b1;
      end
      if (stop) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic mosi_in,
  input  logic ss_n_in,
  output logic sck_edge,
  output logic mosi_s,
  output logic ss_n_s
);
  logic [STAGES-1:0] sck_p, mosi_p, ss_p;
  logic              sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      mosi_p <= '0;
      ss_p   <= '1;
      sck_d  <= 1'b0;
    end else begin
      sck_p  <= {sck_p[STAGES-2:0], sck_in};
      mosi_p <= {mosi_p[STAGES-2:0], mosi_in};
      ss_p   <= {ss_p[STAGES-2:0], ss_n_in};
      sck_d  <= sck_p[STAGES-1];
    end
  end

  assign sck_edge = sck_p[STAGES-1] ^ sck_d;
  assign mosi_s   = mosi_p[STAGES-1];
  assign ss_n_s   = ss_p[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8,
  localparam int CW = $clog2(2 * DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ev,
  input  logic          cpha,
  input  logic          din,
  input  logic          load,
  input  logic [DW-1:0] ldata,
  output logic [DW-1:0] shreg,
  output logic [CW-1:0] cnt,
  output logic          done
);
  localparam logic [CW-1:0] LAST = CW'(2 * DW - 1);

  logic sbit;
  logic is_sample, is_shift;

  assign is_sample = ev && (cnt[0] == cpha);
  assign is_shift  = ev && !is_sample;
  assign done      = ev && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      sbit  <= 1'b0;
      cnt   <= '0;
    end else begin
      if (load) shreg <= ldata;
      if (clr)     cnt <= '0;
      else if (ev) cnt <= cnt + 1'b1;
      if (is_sample) begin
        if (done) shreg <= {shreg[DW-2:0], din};
        else      sbit  <= din;
      end
      if (is_shift && !(cpha && cnt == '0))
        shreg <= {shreg[DW-2:0], sbit};
    end
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = $clog2(2 * DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sck_out,
  output logic          mosi_out,
  input  logic          miso_in,
  input  logic          sck_in,
  input  logic          mosi_in,
  input  logic          ss_n_in,
  output logic          miso_out
);
  logic [DW-1:0] ctrl_q;
  spi_cfg_t      cfg;
  logic          is_master, cpol_w, cpha_w;

  logic wr_ctrl, wr_data, rd_stat, acc_data;
  logic m_busy, m_sck, m_tick, m_start;
  logic s_edge, s_mosi, s_ss_n;
  logic slave_active, busy, edge_evt, din, clr_cnt, load, done_evt;
  logic [DW-1:0] shreg;
  logic [CW-1:0] bit_cnt;
  logic xfer_flag, clr_armed;

  assign cfg       = cfg_decode(ctrl_q[7:0]);
  assign is_master = cfg.master;
  assign cpol_w    = cfg.cpol;
  assign cpha_w    = cfg.cpha;

  assign wr_ctrl  = bus_sel && bus_we && (bus_addr == 2'd0);
  assign wr_data  = bus_sel && bus_we && (bus_addr == 2'd2);
  assign rd_stat  = bus_sel && !bus_we && (bus_addr == 2'd1);
  assign acc_data = bus_sel && (bus_addr == 2'd2);

  assign slave_active = !is_master && (!s_ss_n || (cfg.ign_ss && cpha_w));
  assign busy     = is_master ? m_busy : (slave_active && bit_cnt != '0);
  assign edge_evt = is_master ? m_tick : (s_edge && slave_active);
  assign din      = is_master ? miso_in : s_mosi;
  assign clr_cnt  = is_master ? !m_busy : !slave_active;
  assign m_start  = wr_data && is_master && !m_busy;
  assign load     = wr_data && !busy;

  spi_rate_gen u_rate (
    .clk  (clk),
    .rst_n(rst_n),
    .start(m_start),
    .stop (done_evt),
    .cpol (cpol_w),
    .hdiv (half_div(cfg.rate)),
    .busy (m_busy),
    .sck  (m_sck),
    .tick (m_tick)
  );

  spi_pin_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_in  (sck_in),
    .mosi_in (mosi_in),
    .ss_n_in (ss_n_in),
    .sck_edge(s_edge),
    .mosi_s  (s_mosi),
    .ss_n_s  (s_ss_n)
  );

  spi_shift_core #(.DW(DW)) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_cnt),
    .ev   (edge_evt),
    .cpha (cpha_w),
    .din  (din),
    .load (load),
    .ldata(bus_wdata),
    .shreg(shreg),
    .cnt  (bit_cnt),
    .done (done_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      xfer_flag <= 1'b0;
      clr_armed <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (done_evt)                    xfer_flag <= 1'b1;
      else if (clr_armed && acc_data)  xfer_flag <= 1'b0;
      if (clr_armed && acc_data)       clr_armed <= 1'b0;
      else if (rd_stat && xfer_flag)   clr_armed <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata = ctrl_q;
      2'd1: bus_rdata[7] = xfer_flag;
      2'd2: bus_rdata = shreg;
      default: bus_rdata = '0;
    endcase
  end

  assign sck_out  = is_master ? m_sck : cpol_w;
  assign mosi_out = is_master ? shreg[DW-1] : 1'b0;
  assign miso_out = is_master ? 1'b0 : shreg[DW-1];
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int DW = 8,
  localparam int CW = $clog2(2 * DW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          is_master,
  input logic          cpol_w,
  input logic          sck_out,
  input logic          m_busy,
  input logic          wr_data,
  input logic          edge_evt,
  input logic [DW-1:0] shreg,
  input logic          done_evt,
  input logic          xfer_flag,
  input logic          clr_armed,
  input logic          acc_data,
  input logic          slave_active,
  input logic [CW-1:0] bit_cnt
);
  AST_IDLE_SCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && !m_busy && $stable(cpol_w) && $past(!m_busy) |-> sck_out == cpol_w); // R6

  AST_DONE_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> xfer_flag); // R7

  AST_BUSY_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && m_busy && wr_data && !edge_evt |=> $stable(shreg)); // R9

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_flag && clr_armed && acc_data && !done_evt |=> !xfer_flag); // R8

  AST_UNSELECTED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master && !slave_active |=> bit_cnt == '0); // R12
endmodule

bind spi_port_ctrl spi_port_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .is_master   (is_master),
  .cpol_w      (cpol_w),
  .sck_out     (sck_out),
  .m_busy      (m_busy),
  .wr_data     (wr_data),
  .edge_evt    (edge_evt),
  .shreg       (shreg),
  .done_evt    (done_evt),
  .xfer_flag   (xfer_flag),
  .clr_armed   (clr_armed),
  .acc_data    (acc_data),
  .slave_active(slave_active),
  .bit_cnt     (bit_cnt)
);

// File: tb/tb_spi_port_ctrl.sv
module tb_spi_port_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_sel = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       sck_out, mosi_out, miso_out;
  logic       miso_in = 0, sck_in = 0, mosi_in = 0, ss_n_in = 1;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  spi_port_ctrl dut (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------- bench-side model of the far end when the DUT is master
  bit        mdl_on = 0, mdl_cpol = 0, mdl_cpha = 0;
  int        mdl_d = 1, mdl_edges = 0, mdl_gap_err = 0, mdl_last = 0, mdl_nsh = 0;
  logic [7:0] mdl_tx = 0, mdl_rx = 0;
  logic       prev_sck = 0, prev_mosi = 0;

  always @(negedge clk) begin
    if (mdl_on && sck_out != prev_sck) begin
      bit lead;
      lead = (sck_out != mdl_cpol);
      if (mdl_edges > 0 && (cyc - mdl_last) != mdl_d) mdl_gap_err++;
      mdl_last = cyc;
      mdl_edges++;
      if (lead != mdl_cpha) mdl_rx = {mdl_rx[6:0], prev_mosi};
      else if (mdl_cpha) begin
        if (mdl_nsh < 8) miso_in = mdl_tx[7 - mdl_nsh];
        mdl_nsh++;
      end else begin
        mdl_nsh++;
        if (mdl_nsh < 8) miso_in = mdl_tx[7 - mdl_nsh];
      end
    end
    prev_sck  = sck_out;
    prev_mosi = mosi_out;
  end

  // ---------- helpers
  function automatic int exp_div(input int code);
    return (code == 7) ? 1 : (1 << (code + 1));
  endfunction

  function automatic logic [7:0] mk_ctrl(input bit m, ign, pol, pha, input int rate);
    logic [2:0] r;
    r = 3'(rate);
    return {r[2], 1'b0, ign, m, pol, pha, r[1:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic clear_flag();
    logic [7:0] t;
    bus_rd(2'd1, t);
    bus_rd(2'd2, t);
  endtask

  task automatic master_xfer(input int rate, input bit pol, input bit pha,
                             input logic [7:0] tx, input logic [7:0] far, input bit poke);
    logic [7:0] r;
    int d;
    d = exp_div(rate);
    bus_wr(2'd0, mk_ctrl(1, 0, pol, pha, rate));
    repeat (2) @(negedge clk);
    check(sck_out == pol, "R6 idle level", sck_out, pol);
    mdl_cpol = pol; mdl_cpha = pha; mdl_d = d; mdl_tx = far;
    mdl_edges = 0; mdl_gap_err = 0; mdl_nsh = 0; mdl_rx = 0;
    miso_in = far[7];
    mdl_on = 1;
    bus_wr(2'd2, tx);
    if (poke) begin
      repeat (4 * d) @(negedge clk);
      bus_wr(2'd2, ~tx);
    end
    repeat (16 * d + 8) @(negedge clk);
    mdl_on = 0;
    check(mdl_edges == 16, "R4 edge count", mdl_edges, 16);
    check(mdl_gap_err == 0, "R4 half period", mdl_gap_err, 0);
    check(sck_out == pol, "R6 level after byte", sck_out, pol);
    check(mdl_rx == tx, poke ? "R9 sent byte kept" : "R5 sent byte", mdl_rx, tx);
    bus_rd(2'd2, r);
    check(r == far, "R5 received byte", r, far);
    bus_rd(2'd1, r);
    check(r == 8'h80, "R8 flag kept without status read", r, 8'h80);
    bus_rd(2'd2, r);
    bus_rd(2'd1, r);
    check(r == 8'h00, "R8 flag cleared", r, 0);
  endtask

  localparam int H = 6;

  task automatic slave_run(input bit pol, input bit pha, input bit use_ss,
                           input logic [7:0] mb, output logic [7:0] got);
    got = 0;
    repeat (4) @(negedge clk);
    if (use_ss) ss_n_in = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!pha) begin
        mosi_in = mb[7 - i];
        repeat (H) @(negedge clk);
        got = {got[6:0], miso_out};
        sck_in = ~pol;
        repeat (H) @(negedge clk);
        sck_in = pol;
      end else begin
        sck_in = ~pol;
        mosi_in = mb[7 - i];
        repeat (H) @(negedge clk);
        got = {got[6:0], miso_out};
        sck_in = pol;
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
    ss_n_in = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic slave_setup(input bit pol, input bit pha, input bit ign, input logic [7:0] load);
    bus_wr(2'd0, 8'h00);
    sck_in = pol;
    repeat (5) @(negedge clk);
    bus_wr(2'd0, mk_ctrl(0, ign, pol, pha, 0));
    bus_wr(2'd2, load);
  endtask

  task automatic slave_xfer(input bit pol, input bit pha, input bit ign, input bit use_ss,
                            input logic [7:0] st, input logic [7:0] mb, input string req);
    logic [7:0] got, r;
    slave_setup(pol, pha, ign, st);
    slave_run(pol, pha, use_ss, mb, got);
    check(got == st, {req, " slave sends"}, got, st);
    bus_rd(2'd1, r);
    check(r == 8'h80, {req, " R7 flag"}, r, 8'h80);
    bus_rd(2'd2, r);
    check(r == mb, {req, " slave receives"}, r, mb);
    bus_rd(2'd1, r);
    check(r == 8'h00, "R8 flag cleared after slave", r, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, got;
    int unsigned seed;
    seed = $urandom(32'h1badcafe);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check(sck_out == 0 && mosi_out == 0 && miso_out == 0, "R1 pins", {sck_out, mosi_out, miso_out}, 0);
    bus_rd(2'd0, r); check(r == 0, "R1 control", r, 0);
    bus_rd(2'd1, r); check(r == 0, "R1 status", r, 0);
    bus_rd(2'd2, r); check(r == 0, "R1 data", r, 0);

    // R2 / R3 register map
    bus_wr(2'd0, 8'hA5);
    bus_rd(2'd0, r); check(r == 8'hA5, "R2 control readback", r, 8'hA5);
    bus_rd(2'd3, r); check(r == 0, "R2 address 3", r, 0);
    bus_wr(2'd0, mk_ctrl(0, 0, 1, 0, 0));
    repeat (2) @(negedge clk);
    check(sck_out == 1, "R3 idle-level bit", sck_out, 1);
    bus_wr(2'd2, 8'h3C);
    bus_rd(2'd2, r); check(r == 8'h3C, "R2 data load", r, 8'h3C);

    // R4 every rate code, directed
    for (int k = 0; k < 8; k++)
      master_xfer(k, k[0], k[1], 8'(8'h5A ^ k), 8'(8'hC3 + k), 0);

    // R5 random master traffic
    for (int k = 0; k < 10; k++)
      master_xfer(int'($urandom_range(0, 4)), 1'($urandom), 1'($urandom),
                  8'($urandom), 8'($urandom), 0);

    // R9 write while busy, both phases
    master_xfer(2, 0, 0, 8'h96, 8'h1E, 1);
    master_xfer(3, 1, 1, 8'h81, 8'h7E, 1);

    // R10 slave, all four clock settings with select
    for (int k = 0; k < 4; k++)
      slave_xfer(k[0], k[1], 0, 1, 8'($urandom), 8'($urandom), "R10");
    for (int k = 0; k < 4; k++)
      slave_xfer(1'($urandom), 1'($urandom), 0, 1, 8'($urandom), 8'($urandom), "R10");

    // R11 ignore-select with phase 1
    slave_xfer(0, 1, 1, 0, 8'hB4, 8'h2D, "R11");
    slave_xfer(1, 1, 1, 0, 8'h0F, 8'hF0, "R11");

    // R12 ignore-select with phase 0 has no effect
    slave_setup(0, 0, 1, 8'h6B);
    slave_run(0, 0, 0, 8'h94, got);
    bus_rd(2'd1, r); check(r == 0, "R12 no flag", r, 0);
    bus_rd(2'd2, r); check(r == 8'h6B, "R12 data held", r, 8'h6B);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule